// File: doc/BRIEF.md
# Expansion slot interrupt collector

This block gathers the interrupt request lines of seven expansion slots into one active-low status byte. Slots 9 through 14 are external cards and slot 15 is the on-board video controller. While any slot is pending, the block pulls a single combined, edge-style interrupt line low. That line feeds a peripheral interface input that responds to falling edges. If the line is already low when another slot raises a request, the block lifts it high for one clock so that a fresh falling edge reaches the interface. Software reads the status byte through a plain read port in which bit 7 always reads as one.

Beside the collector sits a small priority encoder. It turns three peripheral interrupt sources into one CPU interrupt level: the serial controller gives level 4, the second interface chip gives level 2 and the first gives level 1. When the selection moves from one active level to another, the old level is dropped for one clock before the new one appears, so the CPU never sees two levels at once. All pins are plain level signals with no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `slot_irq_collector`

## Requirements
- R1: Input `slot_req[i]` belongs to slot number i+9, and its state appears in status bit i. Slot 15, the video controller, uses bit 6.
- R2: A status bit reads 0 while its slot requests an interrupt and 1 once the request is gone. A change on `slot_req` shows in the status on the third rising clock edge after the change, because of two synchronizer flops and the status register.
- R3: During reset and after it, the status byte is 0xFF, `slot_irq_n` is 1 and `cpu_level` is 0.
- R4: When the status is stable, `slot_irq_n` is 0 if any status bit is 0 and 1 if all bits are 1. It changes on the same edge as the status.
- R5: On an edge where some status bit goes from 1 to 0 while `slot_irq_n` is already 0, `slot_irq_n` goes to 1 for exactly one clock. It then returns to 0 if a slot is still pending.
- R6: `slot_status_rd[6:0]` carries the status bits and `slot_status_rd[7]` is always 1.
- R7: The selected level is 4 if `src_serial` is high. Otherwise it is 2 if `src_pif2` is high, otherwise 1 if `src_pif1` is high, otherwise 0. `cpu_level` takes the selected value on the rising edge that samples the inputs.
- R8: When `cpu_level` is non-zero and a different non-zero level is selected, `cpu_level` is 0 for one clock and then takes the new level. `cpu_level` only ever holds 0, 1, 2 or 4.
- R9: Several slots that raise requests together from the idle state give a single falling edge with no high pulse. Removing one of several pending requests does not pulse `slot_irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_req | input | 7 | Slot interrupt requests, active high, bit i for slot i+9 (asynchronous) |
| src_serial | input | 1 | Serial controller interrupt request (synchronous) |
| src_pif2 | input | 1 | Second interface chip interrupt request (synchronous) |
| src_pif1 | input | 1 | First interface chip interrupt request (synchronous) |
| slot_status_rd | output | 8 | Status read value, active-low per slot, bit 7 forced to 1 |
| slot_irq_n | output | 1 | Combined slot interrupt, active low, edge style |
| cpu_level | output | 3 | Selected CPU interrupt level: 0, 1, 2 or 4 |

## Verification
The slot inputs step through all 128 request patterns, first in counting order and then in a scrambled order. Each step therefore starts from a different earlier pattern, and the bench sees pure arrivals, pure removals and mixed changes. The status is checked against the bitwise inverse of the pattern. The combined line is checked both on the edge where the status changes and one edge later. These two samples separate a re-pulse (R5) from a settled level (R4) and from a simultaneous arrival with no pulse (R9). For the level encoder, every ordered pair of the eight source combinations is applied. One sample after the first edge and one after the second separate the plain priority choice (R7) from the released-first step between two active levels (R8).

// File: rtl/slotirq_pkg.sv
package slotirq_pkg;
  localparam int unsigned SLOT_BASE = 9;

  typedef enum logic [2:0] {
    LVL_NONE   = 3'd0,
    LVL_PIF1   = 3'd1,
    LVL_PIF2   = 3'd2,
    LVL_SERIAL = 3'd4
  } cpu_lvl_e;
endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/slot_status_reg.sv
module slot_status_reg #(
  parameter int NS = 7,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] req_s,
  output logic [SW-1:0] status,
  output logic          comb_n
);
  logic [SW-1:0] nxt;
  logic          arrival;
  logic          all_clear;

  always_comb begin
    nxt          = '1;
    nxt[NS-1:0]  = ~req_s;
  end

  // a slot whose bit is still 1 but whose request is now present
  assign arrival   = |(status[NS-1:0] & req_s);
  assign all_clear = &nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '1;
      comb_n <= 1'b1;
    end else begin
      status <= nxt;
      if (all_clear)               comb_n <= 1'b1;
      else if (arrival && !comb_n) comb_n <= 1'b1;
      else                         comb_n <= 1'b0;
    end
  end

  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&status) |-> comb_n);

  p_pending_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&status) && $stable(status)) |-> !comb_n);

  p_repulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!comb_n && arrival && !all_clear) |=> comb_n);

  p_pulse_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_n && !(&status) && !arrival) |=> !comb_n);

  p_removal_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!comb_n && !arrival && !all_clear) |=> !comb_n);
endmodule

// File: rtl/irq_level_select.sv
module irq_level_select
  import slotirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     src_serial,
  input  logic     src_pif2,
  input  logic     src_pif1,
  output cpu_lvl_e level
);
  cpu_lvl_e sel;

  always_comb begin
    if (src_serial)    sel = LVL_SERIAL;
    else if (src_pif2) sel = LVL_PIF2;
    else if (src_pif1) sel = LVL_PIF1;
    else               sel = LVL_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= LVL_NONE;
    end else if (sel != level) begin
      // drop the old level before raising a different one
      if (level != LVL_NONE && sel != LVL_NONE) level <= LVL_NONE;
      else                                      level <= sel;
    end
  end

  p_single_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(level) <= 1);

  p_release_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(level) != LVL_NONE && level != LVL_NONE) |-> level == $past(level));

  p_serial_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_serial && level == LVL_NONE) |=> level == LVL_SERIAL);

  p_quiet_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_serial && !src_pif2 && !src_pif1) |=> level == LVL_NONE);
endmodule

// File: rtl/slot_irq_collector.sv
module slot_irq_collector
  import slotirq_pkg::*;
#(
  parameter int NUM_SLOTS   = 7,
  parameter int STATUS_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_req,
  input  logic                 src_serial,
  input  logic                 src_pif2,
  input  logic                 src_pif1,
  output logic [STATUS_W-1:0]  slot_status_rd,
  output logic                 slot_irq_n,
  output logic [2:0]           cpu_level
);
  localparam int FORCED_W = STATUS_W - NUM_SLOTS;

  logic [NUM_SLOTS-1:0] req_s;
  logic [STATUS_W-1:0]  status;
  cpu_lvl_e             lvl;

  slot_sync #(.W(NUM_SLOTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(slot_req), .dout(req_s)
  );

  slot_status_reg #(.NS(NUM_SLOTS), .SW(STATUS_W)) u_status (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .status(status), .comb_n(slot_irq_n)
  );

  irq_level_select u_level (
    .clk(clk), .rst_n(rst_n), .src_serial(src_serial), .src_pif2(src_pif2),
    .src_pif1(src_pif1), .level(lvl)
  );

  // bits above the last slot always read as 1 (R6)
  assign slot_status_rd = {{FORCED_W{1'b1}}, status[NUM_SLOTS-1:0]};
  assign cpu_level      = lvl;

  p_reset_idle_r3: assert property (@(posedge clk)
    !rst_n |=> (slot_status_rd == '1 && slot_irq_n && cpu_level == 3'd0));
endmodule

// File: tb/test_slot_irq_collector.sv
module test_slot_irq_collector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] slot_req = '0;
  logic       src_serial = 1'b0, src_pif2 = 1'b0, src_pif1 = 1'b0;
  logic [7:0] slot_status_rd;
  logic       slot_irq_n;
  logic [2:0] cpu_level;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slot_irq_collector i_slot_irq_collector (
    .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .src_serial(src_serial),
    .src_pif2(src_pif2), .src_pif1(src_pif1), .slot_status_rd(slot_status_rd),
    .slot_irq_n(slot_irq_n), .cpu_level(cpu_level)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk); #1;
  endtask

  function automatic int exp_lvl(input int s);
    if (s[2]) return 4;
    if (s[1]) return 2;
    if (s[0]) return 1;
    return 0;
  endfunction

  task automatic slot_step(input int q, input int p);
    int arr;
    @(negedge clk);
    slot_req = p[6:0];
    edge_sample(); edge_sample();
    chk(slot_status_rd, {1'b1, ~q[6:0]}, "R2 hold before third edge");
    edge_sample();
    arr = ((p & ~q) != 0) ? 1 : 0;
    chk(slot_status_rd, {1'b1, ~p[6:0]}, "R1/R2/R6 status");
    if (p == 0)                chk(slot_irq_n, 1, "R4 clear");
    else if (arr && q != 0)    chk(slot_irq_n, 1, "R5 re-pulse");
    else                       chk(slot_irq_n, 0, "R9 no pulse");
    edge_sample();
    chk(slot_irq_n, (p == 0) ? 1 : 0, "R4 settled");
  endtask

  task automatic lvl_step(input int a, input int b);
    int la, lb;
    la = exp_lvl(a); lb = exp_lvl(b);
    @(negedge clk);
    {src_serial, src_pif2, src_pif1} = a[2:0];
    edge_sample(); edge_sample();
    chk(cpu_level, la, "R7 settled level");
    @(negedge clk);
    {src_serial, src_pif2, src_pif1} = b[2:0];
    edge_sample();
    chk(cpu_level, (la != 0 && lb != 0 && la != lb) ? 0 : lb, "R8/R7 first edge");
    edge_sample();
    chk(cpu_level, lb, "R7/R8 second edge");
  endtask

  initial begin
    int prev;
    repeat (3) edge_sample();
    chk(slot_status_rd, 8'hFF, "R3 status in reset");
    chk(slot_irq_n, 1, "R3 irq in reset");
    chk(cpu_level, 0, "R3 level in reset");
    @(negedge clk); rst_n = 1'b1;
    edge_sample();
    chk(slot_status_rd, 8'hFF, "R3 status after reset");
    chk(slot_irq_n, 1, "R3 irq after reset");
    chk(cpu_level, 0, "R3 level after reset");
    // video controller slot 15 -> bit 6 (R1)
    slot_step(0, 7'h40);
    chk(slot_status_rd, 8'hBF, "R1 slot 15 on bit 6");
    slot_step(7'h40, 0);
    prev = 0;
    for (int i = 1; i < 128; i++) begin
      slot_step(prev, i);
      prev = i;
    end
    for (int i = 0; i < 128; i++) begin
      int p;
      p = (i * 37 + 11) % 128;
      slot_step(prev, p);
      prev = p;
    end
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        lvl_step(a, b);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule